// File: doc/BRIEF.md
# Programmable AND-array logic with registered output cells

This block is a small programmable logic array held in ordinary registers. A write port programs a set of product terms. Each product term is the AND of any chosen literals. A literal is a device input or a fed-back cell value, taken either true or inverted. Every output cell owns a fixed group of product terms, and the cell's sum is the OR of that group alone. Terms are never shared between cells.

Each output cell can present its sum in one of two ways. It can pass the sum straight through, or it can take the value from a D flip-flop that samples the sum on every rising clock edge. A per-cell enable marks whether the output is driven. The flip-flop state of every cell returns to the term array as an extra literal, so the device can hold state machines as well as plain logic.

The array is programmed by writing one row per product term, plus one control row. After programming, the device runs from `pal_in` and `clk` alone.

Top module: `pal_macro_array`

## Requirements
- R1: A synchronous reset, active high, has these effects. Every cell becomes disabled, with `pal_out` and `pal_valid` at 0. Every cell flip-flop becomes 0. The mode of every cell becomes pass-through. Every product-term row is loaded with all ones, which makes every term false.
- R2: The literal list is ordered as follows. Literal j for j < N_IN is `pal_in[j]`. Literal N_IN+k is the flip-flop value of cell k. Each literal has two bits in a term row, at [2j+1:2j]. The upper bit demands that the literal is 1, and the lower bit demands that it is 0. Code 00 leaves the literal out. A term is the AND of every demand in its row.
- R3: Cell k sums only term rows k*N_PT through k*N_PT+N_PT-1. A term in any other row has no effect on cell k.
- R4: When a cell is enabled and in pass-through mode, its output equals its current sum in the same cycle.
- R5: When a cell is enabled and in registered mode, its output equals the sum that the cell had just before the most recent rising clock edge.
- R6: The feedback literal of a cell is always its flip-flop value. That value is the cell's sum sampled at the previous edge, in either mode.
- R7: When a cell is disabled, both its `pal_out` bit and its `pal_valid` bit are 0. When a cell is enabled, its `pal_valid` bit is 1.
- R8: A write with `cfg_we`=1 takes effect from the next cycle on. If `cfg_addr` is below N_OUT*N_PT, `cfg_data` is stored as that term row. If `cfg_addr` equals N_OUT*N_PT, the control row is written: data bit k selects registered mode (1) for cell k, and data bit N_OUT+k enables cell k. Any higher address is ignored, and nothing changes while `cfg_we`=0.
- R9: A term row of all zeros demands nothing, so the term is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_OUT*N_PT+1) | Term row number or control row number |
| cfg_data | input | 2*(N_IN+N_OUT) | Term row contents or control bits |
| pal_in | input | N_IN | Logic inputs |
| pal_out | output | N_OUT | Cell outputs, 0 when disabled |
| pal_valid | output | N_OUT | Per-cell driven flag |

## Verification
Directed patterns target one behaviour each:
- An empty row separates the true-when-empty rule from the false-when-full reset rows.
- A two-literal row driven with all four input pairs tells the true code apart from the inverted code.
- A cell that feeds back its own inverted state must toggle every cycle, which tells registered timing apart from pass-through timing.
- A second cell that copies the first through feedback tells the one-edge delay apart from a direct path.
- Writes with the strobe low, and writes to an unused address, must leave the outputs untouched.

Random rows with sparse literals, random modes and enables, and random inputs then mix all of these. The results are compared every cycle against a bench model of the array.

// File: rtl/pal_macro_array.sv
module pal_macro_array #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int N_PT  = 4,
  localparam int N_LIT  = N_IN + N_OUT,
  localparam int ROW_W  = 2 * N_LIT,
  localparam int N_ROWS = N_OUT * N_PT,
  localparam int AW     = $clog2(N_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [ROW_W-1:0] cfg_data,
  input  logic [N_IN-1:0]  pal_in,
  output logic [N_OUT-1:0] pal_out,
  output logic [N_OUT-1:0] pal_valid
);

  logic [ROW_W-1:0]  fuse [N_ROWS];
  logic [N_OUT-1:0]  sel_q, oe_q, ff_q, or_sum;
  logic [N_ROWS-1:0] term;
  logic [N_LIT-1:0]  lit;

  assign lit = {ff_q, pal_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < N_ROWS; r++) fuse[r] <= '1;
      sel_q <= '0;
      oe_q  <= '0;
      ff_q  <= '0;
    end else begin
      ff_q <= or_sum;
      if (cfg_we) begin
        for (int r = 0; r < N_ROWS; r++)
          if (cfg_addr == AW'(r)) fuse[r] <= cfg_data;
        if (cfg_addr == AW'(N_ROWS)) begin
          sel_q <= cfg_data[N_OUT-1:0];
          oe_q  <= cfg_data[2*N_OUT-1:N_OUT];
        end
      end
    end
  end

  always_comb begin
    for (int t = 0; t < N_ROWS; t++) begin
      term[t] = 1'b1;
      for (int j = 0; j < N_LIT; j++) begin
        if (fuse[t][2*j+1] && !lit[j]) term[t] = 1'b0;
        if (fuse[t][2*j]   &&  lit[j]) term[t] = 1'b0;
      end
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_or
    assign or_sum[k] = |term[k*N_PT +: N_PT];
  end

  assign pal_out   = oe_q & ((sel_q & ff_q) | (~sel_q & or_sum));
  assign pal_valid = oe_q;

endmodule

// File: rtl/pal_macro_array_chk.sv
module pal_macro_array_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [N_OUT-1:0] or_sum,
  input logic [N_OUT-1:0] ff_q,
  input logic [N_OUT-1:0] sel_q,
  input logic [N_OUT-1:0] oe_q,
  input logic [N_OUT-1:0] pal_out,
  input logic [N_OUT-1:0] pal_valid
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pal_valid == '0 && ff_q == '0 && pal_out == '0));

  assert_feedback_sample_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ff_q == $past(or_sum));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (pal_out & ~pal_valid) == '0);

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> ($stable(sel_q) && $stable(oe_q)));

  for (genvar k = 0; k < N_OUT; k++) begin : g_cell
    assert_reg_output_R5: assert property (@(posedge clk) disable iff (rst)
      (sel_q[k] && $past(sel_q[k]) && oe_q[k] && !$past(rst))
        |-> pal_out[k] == $past(or_sum[k]));
  end

endmodule

bind pal_macro_array pal_macro_array_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .or_sum(or_sum), .ff_q(ff_q),
  .sel_q(sel_q), .oe_q(oe_q), .pal_out(pal_out), .pal_valid(pal_valid)
);

// File: tb/pal_macro_array_bench.sv
module pal_macro_array_bench;
  localparam int N_IN = 8, N_OUT = 4, N_PT = 4;
  localparam int N_LIT = N_IN + N_OUT, ROW_W = 2 * N_LIT;
  localparam int N_ROWS = N_OUT * N_PT, AW = $clog2(N_ROWS + 1);

  logic clk = 0, rst = 1, cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [ROW_W-1:0] cfg_data = '0;
  logic [N_IN-1:0] pal_in = '0;
  logic [N_OUT-1:0] pal_out, pal_valid;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [ROW_W-1:0] m_fuse [N_ROWS];
  logic [N_OUT-1:0] m_sel, m_oe, m_q;

  pal_macro_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_PT(N_PT)) u_pal_macro_array (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .pal_in(pal_in), .pal_out(pal_out), .pal_valid(pal_valid));

  always #4 clk = ~clk;

  function automatic logic [N_OUT-1:0] model_or(input logic [N_IN-1:0] x);
    logic [N_LIT-1:0] l;
    logic [N_OUT-1:0] s;
    l = {m_q, x};
    s = '0;
    for (int r = 0; r < N_ROWS; r++) begin
      logic t;
      t = 1'b1;
      for (int j = 0; j < N_LIT; j++) begin
        if (m_fuse[r][2*j+1] && !l[j]) t = 1'b0;
        if (m_fuse[r][2*j] && l[j]) t = 1'b0;
      end
      if (t) s[r / N_PT] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [ROW_W-1:0] rand_row();
    logic [ROW_W-1:0] d;
    d = '0;
    for (int j = 0; j < N_LIT; j++) begin
      int unsigned r;
      r = $urandom % 9;
      if (r == 6) d[2*j+1] = 1'b1;
      else if (r == 7) d[2*j] = 1'b1;
    end
    return d;
  endfunction

  task automatic check(input string tag, input logic [2*N_OUT-1:0] act,
                       input logic [2*N_OUT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid/out=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic we, input logic [AW-1:0] a,
                      input logic [ROW_W-1:0] d, input logic [N_IN-1:0] x,
                      input string tag);
    logic [N_OUT-1:0] s, e;
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_data = d; pal_in = x;
    #1;
    s = model_or(x);
    e = m_oe & ((m_sel & m_q) | (~m_sel & s));
    check(tag, {pal_valid, pal_out}, {m_oe, e});
    @(posedge clk);
    m_q = s;
    if (we) begin
      for (int r = 0; r < N_ROWS; r++)
        if (a == AW'(r)) m_fuse[r] = d;
      if (a == AW'(N_ROWS)) begin
        m_sel = d[N_OUT-1:0];
        m_oe = d[2*N_OUT-1:N_OUT];
      end
    end
  endtask

  localparam logic [AW-1:0] CTRL = AW'(N_ROWS);

  initial begin
    void'($urandom(32'd1357));
    for (int r = 0; r < N_ROWS; r++) m_fuse[r] = '1;
    m_sel = '0; m_oe = '0; m_q = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state, all cells disabled
    tick(0, '0, '0, 8'hA5, "R1");
    // R1: enable all cells in pass-through; reset rows give false terms
    tick(1, CTRL, ROW_W'(8'hF0), 8'h3C, "R1");
    tick(0, '0, '0, 8'hFF, "R1");
    tick(0, '0, '0, 8'h00, "R1");
    // R9: empty row 0 makes cell 0 true; R3: only cell 0 affected
    tick(1, '0, '0, 8'h11, "R9");
    tick(0, '0, '0, 8'h77, "R9");
    tick(0, '0, '0, 8'h00, "R3");
    // R2: row 4 = in0 true AND in1 inverted
    tick(1, AW'(4), ROW_W'(4'h6), 8'h00, "R2");
    for (int v = 0; v < 4; v++) tick(0, '0, '0, N_IN'(v), "R2");
    // R5/R6: cell2 registered, toggles via own inverted feedback (literal 10)
    tick(1, AW'(8), ROW_W'(1) << 20, 8'h00, "R5");
    tick(1, AW'(12), ROW_W'(1) << 21, 8'h00, "R6");
    tick(1, CTRL, ROW_W'(8'hF4), 8'h00, "R5");
    for (int i = 0; i < 6; i++) tick(0, '0, '0, N_IN'(i), (i % 2) ? "R6" : "R5");
    // R4: pass-through follows inputs in the same cycle
    for (int v = 0; v < 4; v++) tick(0, '0, '0, N_IN'(v), "R4");
    // R8: strobe low and unused address leave everything unchanged
    tick(0, '0, '1, 8'h01, "R8");
    tick(0, CTRL, '0, 8'h02, "R8");
    tick(1, AW'(31), '1, 8'h03, "R8");
    tick(0, '0, '0, 8'h01, "R8");
    // R7: disable cells 1 and 3
    tick(1, CTRL, ROW_W'(8'h54), 8'h01, "R7");
    tick(0, '0, '0, 8'h01, "R7");
    tick(0, '0, '0, 8'h02, "R7");
    // random mix
    for (int r = 0; r < N_ROWS; r++) tick(1, AW'(r), rand_row(), N_IN'($urandom), "R2");
    for (int i = 0; i < 2000; i++) begin
      int unsigned p;
      p = $urandom % 20;
      if (p == 0)
        tick(1, CTRL, ROW_W'($urandom % 256), N_IN'($urandom), "R8");
      else if (p == 1)
        tick(1, AW'($urandom % 32), rand_row(), N_IN'($urandom), "R3");
      else
        tick(0, AW'($urandom), ROW_W'($urandom), N_IN'($urandom), "R4");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule